// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron with Selectable Reset

This block is one digital spiking neuron that runs in discrete time steps. Between two step strobes it gathers signed weighted input pulses into a pending step sum. When the step strobe arrives, it first leaks the stored membrane potential with an arithmetic right shift. It then adds the pending sum, including any pulse presented in the strobe cycle, and compares the result against a programmable threshold of either sign.

When the potential reaches the threshold, the neuron emits a signed spike one cycle after the strobe and re-initialises the potential. The reset mode is chosen at run time. It can clear the potential to zero, take one threshold away from it, or reduce it modulo the threshold. In the modulo case the neuron emits a graded spike that carries every whole multiple of the threshold. There is no refractory period, so the neuron can fire on every step. Weight storage, fan-in routing and learning sit outside the block.

Top module: `lif_modreset`

## Requirements
- R1: While reset is asserted and right after it, spk_valid is 0, and the stored potential and the pending step sum are both zero.
- R2: A pulse with in_valid high is added into the pending step sum. A pulse presented in the same cycle as step belongs to that step. Pulses alone, without a step, never cause a spike.
- R3: On each step, the stored potential is first shifted arithmetically right by leak_shift bits. The pending step sum is then added to the shifted value to form the step total.
- R4: A step whose total is at least theta fires a positive spike. A step whose total is at most -theta fires a negative spike. theta is the unsigned value of thresh, and thresh = 0 never fires. spk_valid is high in the cycle after the step strobe, and only then.
- R5: In mode 2'b00 a spike clears the potential to zero, and spk_weight is +theta or -theta.
- R6: In mode 2'b01 a spike subtracts theta from the potential (adds it for a negative spike), and spk_weight is +theta or -theta.
- R7: In modes 2'b10 and 2'b11, spk_weight is theta times the step total divided by theta, with the quotient truncated toward zero. The remainder, which has magnitude below theta, becomes the new potential.
- R8: There is no refractory time. A potential left at or above theta after a reset fires again on the very next step, even with no new input.
- R9: The pending step sum and the step total both saturate at the signed W-bit limits instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies in_weight |
| in_weight | input | W | Signed weight of the incoming pulse |
| step | input | 1 | Time-step strobe |
| thresh | input | W-1 | Threshold magnitude theta |
| leak_shift | input | SHW | Leak shift amount |
| mode | input | 2 | Reset mode: 00 zero, 01 subtract, 1x modulo |
| spk_valid | output | 1 | Spike present |
| spk_weight | output | W | Signed spike weight |

## Verification
The stimulus walks one potential through a chain of steps, so every result depends on the state the earlier steps left behind. The patterns cover a sub-threshold build-up that only fires once leak and input add together, which separates "leak then add" from other orders. They include negative totals landing exactly on -theta and totals several thresholds deep, which tell the three reset modes apart by weight and by the remainder seen on the next step. They also include a step with no input over a residue still above theta, which exposes any refractory behaviour. Finally, runs of large same-sign pulses and a zero threshold probe saturation and the no-fire case. Directed runs cover reset in the middle of a run, pulses without a strobe, and a pulse that arrives in the same cycle as the strobe.

// File: rtl/lif_modreset.sv
module lif_modreset #(
  parameter int W   = 8,
  parameter int SHW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_weight,
  input  logic                step,
  input  logic        [W-2:0] thresh,
  input  logic      [SHW-1:0] leak_shift,
  input  logic          [1:0] mode,
  output logic                spk_valid,
  output logic signed [W-1:0] spk_weight
);

  localparam logic signed [W:0] VMAX = (W+1)'((2 ** (W-1)) - 1);
  localparam logic signed [W:0] VMIN = -(W+1)'(2 ** (W-1));

  function automatic logic signed [W-1:0] clamp(input logic signed [W:0] x);
    if (x > VMAX)      return VMAX[W-1:0];
    else if (x < VMIN) return VMIN[W-1:0];
    else               return x[W-1:0];
  endfunction

  logic signed [W-1:0] pot, acc;

  logic signed [W-1:0] pulse, acc_nxt, leaked, total;
  logic signed [W-1:0] theta, theta_div, quo, whole, rem;
  logic                fire_p, fire_n, fire;
  logic signed [W-1:0] pot_nxt, w_nxt;

  assign pulse   = in_valid ? in_weight : '0;
  assign acc_nxt = clamp({acc[W-1], acc} + {pulse[W-1], pulse});
  assign leaked  = pot >>> leak_shift;
  assign total   = clamp({leaked[W-1], leaked} + {acc_nxt[W-1], acc_nxt});

  assign theta     = $signed({1'b0, thresh});
  assign theta_div = (thresh == '0) ? W'(1) : theta;
  assign quo       = total / theta_div;
  assign whole     = W'(quo * theta_div);
  assign rem       = total - whole;

  assign fire_p = (thresh != '0) && (total >= theta);
  assign fire_n = (thresh != '0) && (total <= -theta);
  assign fire   = fire_p || fire_n;

  always_comb begin
    pot_nxt = total;
    w_nxt   = fire_p ? theta : -theta;
    if (fire) begin
      unique casez (mode)
        2'b00: pot_nxt = '0;
        2'b01: pot_nxt = fire_p ? total - theta : total + theta;
        2'b1?: begin
          pot_nxt = rem;
          w_nxt   = whole;
        end
        default: pot_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pot        <= '0;
      acc        <= '0;
      spk_valid  <= 1'b0;
      spk_weight <= '0;
    end else begin
      spk_valid <= step && fire;
      if (step) begin
        pot <= pot_nxt;
        acc <= '0;
        if (fire) spk_weight <= w_nxt;
      end else begin
        acc <= acc_nxt;
      end
    end
  end

  // R4
  spike_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_valid |-> $past(step));

  // R4
  zero_thresh_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && thresh == '0) |=> !spk_valid);

  // R2
  hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pot));

  // R2
  acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (acc == '0));

  // R7
  mod_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode[1] && thresh != '0) |=>
      ($signed({pot[W-1], pot}) <  $signed({2'b00, $past(thresh)})) &&
      ($signed({pot[W-1], pot}) > -$signed({2'b00, $past(thresh)})));

  // R5 R6
  unit_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && !$past(mode[1])) |->
      ((spk_weight == $signed({1'b0, $past(thresh)})) ||
       (spk_weight == -$signed({1'b0, $past(thresh)}))));

  // R4
  spike_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spk_valid |-> (spk_weight != '0));

endmodule

// File: tb/tb_lif_modreset.sv
`timescale 1ns/1ps
module tb_lif_modreset;
  localparam int W = 8, SHW = 3, NV = 15;

  logic clk = 0, rst_n = 0, in_valid = 0, step = 0;
  logic signed [W-1:0] in_weight = '0;
  logic [W-2:0] thresh = '0;
  logic [SHW-1:0] leak_shift = '0;
  logic [1:0] mode = '0;
  logic spk_valid;
  logic signed [W-1:0] spk_weight;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lif_modreset #(.W(W), .SHW(SHW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_weight(in_weight),
    .step(step), .thresh(thresh), .leak_shift(leak_shift), .mode(mode),
    .spk_valid(spk_valid), .spk_weight(spk_weight));

  // mode, shift, theta, p0, p1, exp_valid, exp_weight, requirement
  localparam int VEC [NV][8] = '{
    '{0, 0, 10,    3,    4, 0,   0, 4},
    '{0, 1, 10,    5,    2, 1,  10, 3},
    '{1, 0, 10,    9,    6, 1,  10, 6},
    '{1, 0, 10,    0,    0, 0,   0, 6},
    '{1, 0, 10,   10,   10, 1,  10, 6},
    '{1, 0, 10,    0,    0, 1,  10, 8},
    '{2, 0, 10,   20,   12, 1,  30, 7},
    '{2, 0, 10,  -30,  -20, 1, -40, 7},
    '{2, 2, 10,    0,    0, 0,   0, 3},
    '{0, 0, 10,   -5,   -4, 1, -10, 5},
    '{1, 0, 10,  100,  100, 1,  10, 9},
    '{2, 0, 10,    0,    0, 1, 110, 7},
    '{2, 0,  0,   50,    0, 0,   0, 4},
    '{2, 0,  5, -100, -100, 1, -70, 9},
    '{1, 7,  5,    0,    0, 0,   0, 3}
  };

  function automatic string rtag(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(int w);
    @(negedge clk);
    in_valid = 1; in_weight = W'(w);
    @(negedge clk);
    in_valid = 0; in_weight = '0;
  endtask

  task automatic strobe(bit with_pulse, int w);
    @(negedge clk);
    step = 1; in_valid = with_pulse; in_weight = W'(with_pulse ? w : 0);
    @(negedge clk);
    step = 0; in_valid = 0; in_weight = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 spk_valid after reset", int'(spk_valid), 0);

    for (int i = 0; i < NV; i++) begin
      mode = 2'(VEC[i][0]); leak_shift = SHW'(VEC[i][1]); thresh = (W-1)'(VEC[i][2]);
      pulse(VEC[i][3]);
      pulse(VEC[i][4]);
      strobe(0, 0);
      check(rtag(VEC[i][7]), int'(spk_valid), VEC[i][5]);
      if (VEC[i][5] != 0) check(rtag(VEC[i][7]), int'(spk_weight), VEC[i][6]);
    end

    // R1: reset mid-run clears potential and pending sum
    do_reset();
    check("R1 spk_valid cleared", int'(spk_valid), 0);
    mode = 2'b00; leak_shift = '0; thresh = 10;
    // R2: pulses without a step never spike
    for (int k = 0; k < 4; k++) begin
      pulse(50);
      check("R2 no spike without step", int'(spk_valid), 0);
    end
    do_reset();
    // R2: pulse in the strobe cycle counts for that step
    strobe(1, 12);
    check("R2 coincident pulse valid", int'(spk_valid), 1);
    check("R2 coincident pulse weight", int'(spk_weight), 10);
    // R1: potential 9 then reset then 9 must not fire
    pulse(9);
    strobe(0, 0);
    check("R1 sub-threshold", int'(spk_valid), 0);
    do_reset();
    strobe(1, 9);
    check("R1 potential cleared by reset", int'(spk_valid), 0);
    // R7: mode 2'b11 acts as modulo: 9 + 25 = 34 -> 30, keeps 4
    mode = 2'b11;
    strobe(1, 25);
    check("R7 mode3 valid", int'(spk_valid), 1);
    check("R7 mode3 weight", int'(spk_weight), 30);
    // R7: residue 4 plus 5 = 9 stays below 10
    strobe(1, 5);
    check("R7 residue kept", int'(spk_valid), 0);
    // R4: spike lasts one cycle only
    strobe(1, 1);
    check("R4 fires at 10", int'(spk_valid), 1);
    @(negedge clk);
    check("R4 single cycle", int'(spk_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule